// File: doc/BRIEF.md
# Symmetric FIR Filter with One Time-Shared Multiplier

This block is an eight-tap, fixed-point FIR filter with even symmetry. Each output needs four coefficient products. The block computes all four on a single signed multiplier. The multiplier is reused across four fast-clock cycles, or slots, that together make up one sample period.

A free-running two-bit slot counter selects which mirrored-tap sum and which coefficient feed the multiplier. It also raises a sample strobe in slot 0, and the block accepts a new input only in that slot. Three products are parked in registers. In slot 3 the fourth product arrives live and the four are added together, saturated and registered.

A second output gives the input sample, delayed so that it lines up with the filtered result. The upstream logic must present each new sample while the strobe is high. The downstream logic may read both outputs in any slot of a sample period.

Top module: `symfir_shared`

## Requirements
- R1: `smp_stb` is high in the first cycle after reset is released, then in exactly one cycle of every four.
- R2: `din` is sampled only on the clock edge that ends a cycle in which `smp_stb` is high. Any value on `din` in the other three cycles has no effect on either output.
- R3: Let x[n] be the sample taken in period n. Throughout period n+2, `y_out` equals the sum over j=0..3 of c_j*(x[n-j]+x[n-7+j]), where c0..c3 are the four CW-bit signed fields of `COEFS`, with c_j at bits [j*CW +: CW]. The output is one period later than a fully parallel filter that registers its output once per period.
- R4: Throughout period n+2, `x_dly` equals x[n], so it stays aligned with the `y_out` value computed for that same sample.
- R5: Both outputs change only on the clock edge that ends slot 3. They hold their values through the other three slots.
- R6: A result above 2^(OW-1)-1 is output as 2^(OW-1)-1, and a result below -2^(OW-1) is output as -2^(OW-1).
- R7: An active-low asynchronous reset clears the slot counter, the sample history and both outputs. Samples from before reset never contribute to a later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per sample |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DW | Signed input sample, taken while `smp_stb` is high |
| smp_stb | output | 1 | High in slot 0 of each sample period |
| y_out | output | OW | Signed, saturated filter result |
| x_dly | output | DW | Input sample delayed to line up with `y_out` |

## Verification
The bench feeds a single impulse first, so a slot-to-coefficient mapping in the wrong order shows up as a mispermuted impulse response. Full-scale positive and negative runs drive the sum beyond the output range. A missing clamp would wrap to the opposite sign, and a clamp to the wrong bound would show a wrong limit value.

Junk values are placed on `din` in slots 1 to 3. A design that sampled the input outside the strobe would then leak the junk into `x_dly` and `y_out`. Both outputs are read in slot 0 and again in slot 2, which catches any update outside slot 3 and any latency off by one period. A reset in the middle of a run follows a full-scale negative history, so taps that survived the reset would show up as a large negative output.

// File: rtl/symfir_shared.sv
module symfir_shared #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int OW = 24,
  parameter logic [4*CW-1:0] COEFS = {16'd120, 16'd40, 16'hFFF7, 16'd3}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] din,
  output logic                 smp_stb,
  output logic signed [OW-1:0] y_out,
  output logic signed [DW-1:0] x_dly
);
  localparam int NT = 8;
  localparam int NP = NT / 2;
  localparam int SW = DW + 1;
  localparam int PW = SW + CW;
  localparam int AW = PW + 2;
  localparam logic signed [AW-1:0] OMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] OMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic [1:0]                slot;
  logic signed [DW-1:0]      xin_q;
  logic signed [DW-1:0]      tap  [NT];
  logic signed [SW-1:0]      psum [NP];
  logic signed [CW-1:0]      coef [NP];
  logic signed [PW-1:0]      preg [NP-1];
  logic signed [PW-1:0]      mul;
  logic signed [AW-1:0]      acc;
  logic signed [AW-1:0]      sat;

  assign smp_stb = (slot == 2'd0);

  genvar j;
  generate
    for (j = 0; j < NP; j++) begin : g_pre
      assign psum[j] = SW'(tap[j]) + SW'(tap[NT-1-j]);
      assign coef[j] = signed'(COEFS[j*CW +: CW]);
    end
  endgenerate

  assign mul = PW'(psum[slot]) * PW'(coef[slot]);
  assign acc = AW'(preg[0]) + AW'(preg[1]) + AW'(preg[2]) + AW'(mul);
  assign sat = (acc > OMAX) ? OMAX : (acc < OMIN) ? OMIN : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '0;
      xin_q <= '0;
      y_out <= '0;
      x_dly <= '0;
      for (int k = 0; k < NT; k++) tap[k] <= '0;
      for (int k = 0; k < NP-1; k++) preg[k] <= '0;
    end else begin
      slot <= slot + 2'd1;
      if (smp_stb) xin_q <= din;
      for (int k = 0; k < NP-1; k++)
        if (slot == 2'(k)) preg[k] <= mul;
      if (slot == 2'd3) begin
        y_out  <= sat[OW-1:0];
        x_dly  <= tap[0];
        tap[0] <= xin_q;
        for (int k = 1; k < NT; k++) tap[k] <= tap[k-1];
      end
    end
  end

  // R1
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
  // R1
  stb_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd3) |=> smp_stb);
  // R2
  xin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(xin_q));
  // R5
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != 2'd3) |=> $stable(y_out));
  // R5
  xdly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != 2'd3) |=> $stable(x_dly));
  // R4
  xdly_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd3) |=> (x_dly == $past(tap[0])));
endmodule

// File: tb/sim_symfir_shared.sv
module sim_symfir_shared;
  localparam int DW = 16, CW = 16, OW = 24;
  localparam longint C [4] = '{3, -9, 40, 120};
  localparam longint YMAX = (64'sd1 <<< (OW-1)) - 1;
  localparam longint YMIN = -(64'sd1 <<< (OW-1));
  localparam int NV = 28;
  localparam int VEC [NV] = '{
    1, 0, 0, 0, 0, 0, 0, 0,
    100, -200, 1234, -4321,
    32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767,
    -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768};

  logic clk = 0, rst_n = 0;
  logic signed [DW-1:0] din = '0;
  logic smp_stb;
  logic signed [OW-1:0] y_out;
  logic signed [DW-1:0] x_dly;
  int total = 0, fails = 0;
  int hist [0:63];
  bit done = 0;

  always #10 clk = ~clk;

  symfir_shared #(.DW(DW), .CW(CW), .OW(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .smp_stb(smp_stb), .y_out(y_out), .x_dly(x_dly));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint hv(input int i);
    return (i < 0) ? 0 : longint'(hist[i]);
  endfunction

  function automatic longint ref_y(input int n);
    longint s = 0;
    for (int j = 0; j < 4; j++) s += C[j] * (hv(n-j) + hv(n-7+j));
    if (s > YMAX) s = YMAX;
    if (s < YMIN) s = YMIN;
    return s;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    longint ey, ex;
    repeat (3) @(negedge clk);
    chk(y_out == 0, "R7 reset y_out", y_out, 0);
    chk(x_dly == 0, "R7 reset x_dly", x_dly, 0);
    rst_n = 1;
    for (int p = 0; p < NV + 2; p++) begin
      ey = (p >= 2) ? ref_y(p-2) : 0;
      ex = (p >= 2) ? hv(p-2) : 0;
      chk(smp_stb == 1, "R1 strobe in slot0", smp_stb, 1);
      chk(y_out == ey, "R3 R6 y_out", y_out, ey);
      chk(x_dly == ex, "R4 x_dly", x_dly, ex);
      din = (p < NV) ? DW'(VEC[p]) : '0;
      hist[p] = (p < NV) ? VEC[p] : 0;
      @(negedge clk);
      din = 16'sh5A5A;  // R2 junk outside strobe
      @(negedge clk);
      chk(smp_stb == 0, "R1 strobe low slot2", smp_stb, 0);
      chk(y_out == ey, "R5 y_out hold", y_out, ey);
      chk(x_dly == ex, "R5 R2 x_dly hold", x_dly, ex);
      @(negedge clk);
      @(negedge clk);
    end
    // R6 explicit limits seen in the run
    chk(ref_y(19) == YMAX, "R6 positive clamp model", ref_y(19), YMAX);
    // R7 mid-run reset after negative full-scale history
    rst_n = 0;
    @(negedge clk);
    chk(y_out == 0, "R7 mid reset y_out", y_out, 0);
    chk(x_dly == 0, "R7 mid reset x_dly", x_dly, 0);
    chk(smp_stb == 1, "R7 R1 mid reset strobe", smp_stb, 1);
    rst_n = 1;
    din = 16'sd500;
    repeat (4) @(negedge clk);
    din = '0;
    chk(y_out == 0, "R7 no stale history p1", y_out, 0);
    repeat (4) @(negedge clk);
    chk(y_out == 3 * 500, "R7 R3 first sample after reset", y_out, 1500);
    chk(x_dly == 500, "R7 R4 first x_dly after reset", x_dly, 500);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule